// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a non-return-to-zero serial line into characters. The line idles high. Each frame begins with a low start bit. The data bits follow, least significant first, then an optional parity bit, then one or two stop bits. The word length, the parity mode and the stop-bit count come from static configuration inputs, which are held stable while a frame is in progress.

A 16-bit divisor sets the bit rate. Every bit period is cut into eight sub-bit ticks. Each bit is decided by a majority vote of the line taken on the fourth, fifth and sixth ticks. Reception is double-buffered: a shift register assembles the incoming character while the previous one waits in a holding register behind a ready flag.

Parity, framing, overrun and break conditions set sticky flags. A combined error output is the OR of all four flags, and break also has an output of its own. A small register port returns the held character or the status byte in the low half of a 16-bit word. Software clears the flags by writing ones to them.

Top module: `serial_rx_unit`

## Requirements
- R1: The sub-bit tick period is `baud_div`+1 clocks when `baud_div` is nonzero and 2 clocks when it is zero, and a bit lasts 8 ticks. The holding register is loaded on the clock after the sixth tick of the last stop bit.
- R2: `word_len` value n (0 to 7) selects n+1 data bits, received least significant bit first. The character is right-justified in the holding register, and the bits above the word length read as zero.
- R3: Each bit value is the majority of the line samples taken on ticks 4, 5 and 6 of its bit period. One corrupted sample does not change the bit, and two corrupted samples do.
- R4: A low level that does not last through ticks 4 to 6 of the start bit is treated as noise. It delivers no character and sets no flag.
- R5: `parity_mode` 2'b01 selects odd parity and 2'b10 selects even parity. 2'b00 and 2'b11 both mean that no parity bit is sent. A parity mismatch sets the parity flag, and the character is still delivered.
- R6: A stop bit that is sampled low sets the framing flag, and the character is still delivered.
- R7: A delivered character sets the ready flag. A data read (`rd_en` with `reg_sel`=0) clears it.
- R8: If a character completes while the ready flag is set and no data read happens in that cycle, the overrun flag is set and the held character is kept.
- R9: A frame whose start, data, parity and stop samples are all low is a break. A break sets the break flag and the framing flag, and it loads nothing and leaves the ready flag unchanged.
- R10: `rx_error` is the OR of the parity, overrun, framing and break flags. A write with `reg_sel`=1 clears each flag whose bit is 1 in `wr_data` (bit 1 parity, bit 2 overrun, bit 3 framing, bit 4 break). Writes with `reg_sel`=0 and all bits 15:8 of `wr_data` have no effect.
- R11: `rd_data` bits 15:8 are always zero. With `reg_sel`=0 the low byte is the held character. With `reg_sel`=1 the low byte is the status byte: bit 0 ready, bit 1 parity, bit 2 overrun, bit 3 framing, bit 4 break, bit 5 combined error, bits 7:6 zero.
- R12: With `two_stop` set, a second stop bit is expected, and a low level in either stop bit sets the framing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Serial input line, idles high |
| baud_div | input | 16 | Bit-rate divisor |
| word_len | input | 3 | Data bits minus one |
| parity_mode | input | 2 | 01 odd, 10 even, 00/11 no parity |
| two_stop | input | 1 | Expect two stop bits |
| rd_en | input | 1 | Read strobe, a data read clears ready |
| reg_sel | input | 1 | 0 selects the held character, 1 selects status |
| wr_en | input | 1 | Write strobe for clearing flags |
| wr_data | input | 16 | Write data, only bits 4:1 act |
| rd_data | output | 16 | Read data, zero upper byte |
| rx_ready | output | 1 | A character is waiting |
| rx_error | output | 1 | Any error flag is set |
| rx_break | output | 1 | Break flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit divisor, 8-bit characters and a two-stage input synchronizer. It changes the divisor at run time between 0, 1, 2, 3, 5, 7 and 9. This covers the special tick period for a zero divisor and several longer bit periods. At a divisor of 7 each tick lasts eight clocks, so a pulse on the line can be placed over exactly one vote sample or over two. The latency from the start edge to the ready flag is measured for the divisor values 0 and 9.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W        = 8;
    localparam int LEN_W         = $clog2(CHAR_W);
    localparam int SUBTICKS      = 8;
    localparam int SUB_W         = $clog2(SUBTICKS) + 1;
    localparam int VOTE_A        = SUBTICKS / 2;
    localparam int VOTE_B        = VOTE_A + 1;
    localparam int VOTE_C        = VOTE_A + 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        PM_NONE  = 2'b00,
        PM_ODD   = 2'b01,
        PM_EVEN  = 2'b10,
        PM_NONE2 = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic par_used(input par_mode_e m);
        return (m == PM_ODD) || (m == PM_EVEN);
    endfunction

    function automatic logic par_bit(input logic [CHAR_W-1:0] d, input par_mode_e m);
        return (m == PM_ODD) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? DIV_W'(1) : div;
    assign tick = !hold && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || hold)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line,
    input  logic              tick,
    input  logic [LEN_W-1:0]  wlen,
    input  par_mode_e         pmode,
    input  logic              two_stop,
    output logic              idle,
    output logic              done,
    output rx_frame_t         frame
);
    rx_state_e          state;
    logic [SUB_W-1:0]   tcnt;
    logic [SUB_W-1:0]   tnext;
    logic [1:0]         smp;
    logic [LEN_W-1:0]   bidx;
    logic [CHAR_W-1:0]  shreg;
    logic               allz;
    logic               perr_acc;
    logic               ferr_acc;
    logic               vote;
    logic               brk_now;

    assign tnext   = tcnt + SUB_W'(1);
    assign vote    = vote3({smp, line});
    assign brk_now = allz && !vote;
    assign idle    = (state == RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            smp      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            allz     <= 1'b0;
            perr_acc <= 1'b0;
            ferr_acc <= 1'b0;
            done     <= 1'b0;
            frame    <= '0;
        end else begin
            done <= 1'b0;
            if (state == RX_IDLE) begin
                tcnt <= '0;
                if (!line) begin
                    state    <= RX_START;
                    shreg    <= '0;
                    bidx     <= '0;
                    allz     <= 1'b1;
                    perr_acc <= 1'b0;
                    ferr_acc <= 1'b0;
                end
            end else if (tick) begin
                tcnt <= (tnext == SUB_W'(SUBTICKS)) ? '0 : tnext;
                if (tnext == SUB_W'(VOTE_A) || tnext == SUB_W'(VOTE_B))
                    smp <= {smp[0], line};
                if (tnext == SUB_W'(VOTE_C)) begin
                    if (vote) allz <= 1'b0;
                    case (state)
                        RX_START: if (smp != 2'b00 || line) state <= RX_IDLE;
                        RX_DATA:  shreg[bidx] <= vote;
                        RX_PAR:   perr_acc <= (vote != par_bit(shreg, pmode));
                        RX_STOP1: begin
                            if (two_stop) begin
                                ferr_acc <= !vote;
                            end else begin
                                done        <= 1'b1;
                                state       <= RX_IDLE;
                                frame.data  <= shreg;
                                frame.brk   <= brk_now;
                                frame.ferr  <= !vote;
                                frame.perr  <= perr_acc && !brk_now;
                            end
                        end
                        RX_STOP2: begin
                            done        <= 1'b1;
                            state       <= RX_IDLE;
                            frame.data  <= shreg;
                            frame.brk   <= brk_now;
                            frame.ferr  <= ferr_acc || !vote;
                            frame.perr  <= perr_acc && !brk_now;
                        end
                        default: ;
                    endcase
                end
                if (tnext == SUB_W'(SUBTICKS)) begin
                    case (state)
                        RX_START: state <= RX_DATA;
                        RX_DATA: begin
                            if (bidx == wlen)
                                state <= par_used(pmode) ? RX_PAR : RX_STOP1;
                            else
                                bidx <= bidx + LEN_W'(1);
                        end
                        RX_PAR:   state <= RX_STOP1;
                        RX_STOP1: state <= RX_STOP2;
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [7:0]        wr_byte,
    output logic [15:0]       rd_data,
    output logic [CHAR_W-1:0] char_q,
    output logic              ready,
    output logic              err,
    output logic              brk
);
    logic perr, ovr, ferr;
    logic rd_clear;
    logic [3:0] clr;
    logic [7:0] status;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_byte[7:5], wr_byte[0]};
    assign rd_clear = rd_en && !reg_sel;
    assign clr      = (wr_en && reg_sel) ? wr_byte[4:1] : 4'b0000;
    assign err      = perr | ovr | ferr | brk;
    assign status   = {2'b00, err, brk, ferr, ovr, perr, ready};
    assign rd_data  = {8'h00, reg_sel ? status : 8'(char_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            ready  <= 1'b0;
            perr   <= 1'b0;
            ovr    <= 1'b0;
            ferr   <= 1'b0;
            brk    <= 1'b0;
            char_q <= '0;
        end else begin
            if (rd_clear) ready <= 1'b0;
            perr <= perr & ~clr[0];
            ovr  <= ovr  & ~clr[1];
            ferr <= ferr & ~clr[2];
            brk  <= brk  & ~clr[3];
            if (done) begin
                if (frame.brk) begin
                    brk  <= 1'b1;
                    ferr <= 1'b1;
                end else begin
                    if (frame.perr) perr <= 1'b1;
                    if (frame.ferr) ferr <= 1'b1;
                    if (ready && !rd_clear) begin
                        ovr <= 1'b1;
                    end else begin
                        char_q <= frame.data;
                        ready  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [2:0]       word_len,
    input  logic [1:0]       parity_mode,
    input  logic             two_stop,
    input  logic             rd_en,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    output logic             rx_ready,
    output logic             rx_error,
    output logic             rx_break
);
    logic              line_s;
    logic              tick;
    logic              fr_idle;
    logic              frame_done;
    rx_frame_t         frame_q;
    logic [CHAR_W-1:0] held_char;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[15:8];

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s)
    );

    serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .hold (fr_idle),
        .div  (baud_div),
        .tick (tick)
    );

    serial_rx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .line     (line_s),
        .tick     (tick),
        .wlen     (word_len),
        .pmode    (par_mode_e'(parity_mode)),
        .two_stop (two_stop),
        .idle     (fr_idle),
        .done     (frame_done),
        .frame    (frame_q)
    );

    serial_rx_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .done    (frame_done),
        .frame   (frame_q),
        .rd_en   (rd_en),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wr_byte (wr_data[7:0]),
        .rd_data (rd_data),
        .char_q  (held_char),
        .ready   (rx_ready),
        .err     (rx_error),
        .brk     (rx_break)
    );
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk
    import serial_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              frame_done,
    input rx_frame_t         frame_q,
    input logic [CHAR_W-1:0] held_char,
    input logic              rd_en,
    input logic              reg_sel,
    input logic              rx_ready,
    input logic              rx_error,
    input logic              rx_break
);
    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R7
    ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done && !frame_q.brk && !rx_ready |=> rx_ready);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && !reg_sel && rx_ready && !frame_done |=> !rx_ready);

    // R8
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done && !frame_q.brk && rx_ready && !(rd_en && !reg_sel)
        |=> rx_error && $stable(held_char));

    // R9
    break_flag_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done && frame_q.brk && !(rd_en && !reg_sel)
        |=> rx_break && rx_error && $stable(rx_ready));

    // R10
    err_cover_chk: assert property (@(posedge clk) disable iff (rst)
        rx_break |-> rx_error);
endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .frame_done (frame_done),
    .frame_q    (frame_q),
    .held_char  (held_char),
    .rd_en      (rd_en),
    .reg_sel    (reg_sel),
    .rx_ready   (rx_ready),
    .rx_error   (rx_error),
    .rx_break   (rx_break)
);

// File: tb/serial_rx_unit_test.sv
`timescale 1ns/1ps
module serial_rx_unit_test;

    typedef struct packed {
        logic [15:0] div;
        logic [2:0]  wl;
        logic [1:0]  pm;
        logic        two;
        logic [7:0]  data;
        logic [7:0]  exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'd0, 3'd7, 2'b00, 1'b0, 8'hA5, 8'hA5},
        '{16'd3, 3'd7, 2'b10, 1'b0, 8'h3C, 8'h3C},
        '{16'd7, 3'd4, 2'b01, 1'b1, 8'hDB, 8'h1B},
        '{16'd1, 3'd0, 2'b10, 1'b0, 8'h01, 8'h01},
        '{16'd2, 3'd6, 2'b00, 1'b1, 8'hFF, 8'h7F},
        '{16'd5, 3'd7, 2'b01, 1'b0, 8'h00, 8'h00},
        '{16'd0, 3'd2, 2'b01, 1'b1, 8'h06, 8'h06}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic [15:0] baud_div = 16'd0;
    logic [2:0]  word_len = 3'd7;
    logic [1:0]  parity_mode = 2'b00;
    logic        two_stop = 1'b0;
    logic        rd_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        rx_ready, rx_error, rx_break;

    int checks = 0;
    int failures = 0;
    longint cyc = 0;
    longint start_cyc = 0;
    longint rise_cyc = 0;
    logic   ready_q = 1'b0;

    serial_rx_unit uut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .baud_div(baud_div),
        .word_len(word_len), .parity_mode(parity_mode), .two_stop(two_stop),
        .rd_en(rd_en), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rx_ready(rx_ready), .rx_error(rx_error),
        .rx_break(rx_break)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rx_ready && !ready_q) rise_cyc = cyc;
        ready_q = rx_ready;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input bit s, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        reg_sel = s;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input bit s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        reg_sel = s;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 16'h0000;
    endtask

    task automatic clear_all();
        logic [15:0] v;
        wr(1'b1, 16'h001E);
        rd(1'b0, v);
    endtask

    // glitch_bit >= 0 inverts that data bit from clock 28 of the bit for glitch_len clocks
    task automatic send_frame(input int div, input int wl, input int pm, input bit two,
                              input logic [7:0] d, input bit bad_par, input bit bad_s1,
                              input bit bad_s2, input int glitch_bit, input int glitch_len);
        int p;
        int bitclk;
        logic [7:0] dm;
        logic pb;
        baud_div = 16'(div);
        word_len = 3'(wl);
        parity_mode = 2'(pm);
        two_stop = two;
        p = (div == 0) ? 2 : div + 1;
        bitclk = 8 * p;
        wait_n(4);
        rx_in = 1'b0;
        start_cyc = cyc;
        wait_n(bitclk);
        dm = 8'h00;
        for (int i = 0; i <= wl; i++) begin
            dm[i] = d[i];
            rx_in = d[i];
            if (i == glitch_bit) begin
                wait_n(28);
                rx_in = ~d[i];
                wait_n(glitch_len);
                rx_in = d[i];
                wait_n(bitclk - 28 - glitch_len);
            end else begin
                wait_n(bitclk);
            end
        end
        if (pm == 1 || pm == 2) begin
            pb = (pm == 2) ? (^dm) : ~(^dm);
            rx_in = bad_par ? ~pb : pb;
            wait_n(bitclk);
        end
        rx_in = ~bad_s1;
        wait_n(bitclk);
        if (two) begin
            rx_in = ~bad_s2;
            wait_n(bitclk);
        end
        rx_in = 1'b1;
        wait_n(2 * bitclk);
    endtask

    initial begin
        logic [15:0] v;
        int p;
        longint lat;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);

        // Reset state
        chk(rx_ready == 1'b0 && rx_error == 1'b0 && rx_break == 1'b0, "R7", "reset outputs",
            {rx_ready, rx_error, rx_break}, 0);
        rd(1'b1, v);
        chk(v == 16'h0000, "R11", "reset status", v, 16'h0000);
        rd(1'b0, v);
        chk(v == 16'h0000, "R11", "reset data", v, 16'h0000);

        // Table of frame formats
        for (int k = 0; k < NVEC; k++) begin
            send_frame(int'(VECS[k].div), int'(VECS[k].wl), int'(VECS[k].pm), VECS[k].two,
                       VECS[k].data, 1'b0, 1'b0, 1'b0, -1, 0);
            chk(rx_ready == 1'b1, "R7", $sformatf("ready vec %0d", k), rx_ready, 1);
            rd(1'b1, v);
            chk(v == 16'h0001, "R5", $sformatf("clean status vec %0d", k), v, 16'h0001);
            rd(1'b0, v);
            chk(v == {8'h00, VECS[k].exp}, "R2", $sformatf("data vec %0d", k), v, VECS[k].exp);
            chk(rx_ready == 1'b0, "R7", $sformatf("ready cleared vec %0d", k), rx_ready, 0);
        end

        // R1: start edge to ready latency
        for (int t = 0; t < 2; t++) begin
            p = (t == 0) ? 2 : 10;
            send_frame((t == 0) ? 0 : 9, 7, 0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0, -1, 0);
            lat = rise_cyc - start_cyc;
            chk(lat >= 78 * p + 2 && lat <= 78 * p + 6, "R1",
                $sformatf("latency div=%0d", (t == 0) ? 0 : 9), lat, 78 * p + 4);
            clear_all();
        end

        // R3: one corrupted vote sample is outvoted
        send_frame(7, 7, 0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 2, 10);
        rd(1'b0, v);
        chk(v == 16'h0055, "R3", "single sample glitch", v, 16'h0055);
        // R3: two corrupted samples flip the bit
        send_frame(7, 7, 0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 2, 18);
        rd(1'b0, v);
        chk(v == 16'h0051, "R3", "double sample glitch", v, 16'h0051);
        clear_all();

        // R4: short low pulse on idle line
        baud_div = 16'd7;
        wait_n(4);
        rx_in = 1'b0;
        wait_n(16);
        rx_in = 1'b1;
        wait_n(800);
        rd(1'b1, v);
        chk(v == 16'h0000 && !rx_ready, "R4", "noise start", v, 16'h0000);

        // R5: parity mismatch, even mode
        send_frame(3, 7, 2, 1'b0, 8'h5A, 1'b1, 1'b0, 1'b0, -1, 0);
        rd(1'b1, v);
        chk(v == 16'h0023, "R5", "parity error status", v, 16'h0023);
        chk(rx_error == 1'b1, "R10", "error output on parity", rx_error, 1);
        wr(1'b1, 16'h0002);
        rd(1'b1, v);
        chk(v == 16'h0001 && !rx_error, "R10", "parity flag cleared", v, 16'h0001);
        rd(1'b0, v);
        chk(v == 16'h005A, "R5", "data despite parity error", v, 16'h005A);

        // R5: mode 2'b11 carries no parity bit
        send_frame(3, 7, 3, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0, -1, 0);
        rd(1'b1, v);
        chk(v == 16'h0001, "R5", "mode 11 status", v, 16'h0001);
        rd(1'b0, v);
        chk(v == 16'h00C3, "R5", "mode 11 data", v, 16'h00C3);

        // R6: low stop bit
        send_frame(2, 7, 0, 1'b0, 8'h3E, 1'b0, 1'b1, 1'b0, -1, 0);
        rd(1'b1, v);
        chk(v == 16'h0029, "R6", "framing status", v, 16'h0029);
        rd(1'b0, v);
        chk(v == 16'h003E, "R6", "data despite framing", v, 16'h003E);
        clear_all();

        // R12: second stop bit low
        send_frame(2, 7, 1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b1, -1, 0);
        rd(1'b1, v);
        chk(v == 16'h0029, "R12", "second stop framing", v, 16'h0029);
        clear_all();

        // R8: overrun keeps the first character
        send_frame(1, 7, 0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, -1, 0);
        send_frame(1, 7, 0, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, -1, 0);
        rd(1'b1, v);
        chk(v == 16'h0025, "R8", "overrun status", v, 16'h0025);
        rd(1'b0, v);
        chk(v == 16'h0011, "R8", "kept character", v, 16'h0011);
        clear_all();

        // R9: break, line low across a whole frame
        baud_div = 16'd3;
        word_len = 3'd7;
        parity_mode = 2'b00;
        two_stop = 1'b0;
        wait_n(4);
        rx_in = 1'b0;
        wait_n(10 * 32);
        rx_in = 1'b1;
        wait_n(3 * 32);
        chk(rx_break == 1'b1 && rx_error == 1'b1, "R9", "break outputs",
            {rx_break, rx_error}, 2'b11);
        rd(1'b1, v);
        chk(v == 16'h0038, "R9", "break status", v, 16'h0038);

        // R10: writes to upper byte and to the data select have no effect
        wr(1'b1, 16'hFF00);
        rd(1'b1, v);
        chk(v == 16'h0038, "R10", "upper byte write ignored", v, 16'h0038);
        wr(1'b0, 16'h00FF);
        rd(1'b1, v);
        chk(v == 16'h0038, "R10", "data select write ignored", v, 16'h0038);
        wr(1'b1, 16'h0010);
        rd(1'b1, v);
        chk(v == 16'h0028 && !rx_break, "R10", "break cleared alone", v, 16'h0028);
        wr(1'b1, 16'h0008);
        rd(1'b1, v);
        chk(v == 16'h0000 && !rx_error, "R10", "all clear", v, 16'h0000);
        chk(v[15:8] == 8'h00, "R11", "upper byte zero", v[15:8], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule